// File: doc/BRIEF.md
# Trap Return State Update Unit

This unit executes the two trap-return instructions of a RISC-V style core that may carry the hypervisor extension: the supervisor return and the machine return. For each one-cycle request it checks the return for legality, using the current privilege, the virtualization flag, the trap-control bits, the return-PC alignment and the count of memory-protection rules. It then either reports one exception with a cause code or commits the new privilege, the new virtualization flag, the rewritten status fields and the return PC.

All results are registered. They appear in the clock cycle after the request. The state outputs are the unit's own copy of the most recently committed values. The surrounding core loads them into its architectural registers when `done` pulses. Only a successful return changes these outputs.

Top module: `trap_return_unit`

## Requirements
- R1: After synchronous reset, `done`, `fault` and `fault_cause` are 0. Every `new_*` state output and `ret_pc` is also 0.
- R2: Privilege is checked first. A supervisor return (`req_is_mret`=0) at user level (`cur_priv`=0) faults with cause 2. A machine return (`req_is_mret`=1) at any level other than machine (`cur_priv`=3) also faults with cause 2. Supervisor is encoded as 1.
- R3: Alignment is checked second. When `cfg_has_c`=0 and bits [1:0] of the selected return PC are not both zero, the unit faults with cause 0. The selected PC is `sepc` for a supervisor return and `mepc` for a machine return. When `cfg_has_c`=1, misalignment never faults.
- R4: Third check, supervisor return only. If `st_tsr`=1 and `cur_priv` is not 3, the unit faults with cause 2.
- R5: Fourth check, supervisor return only. If `cfg_has_h`=1, `cur_virt`=1 and `hs_vtsr`=1, the unit faults with cause 22.
- R6: Supervisor return with `cfg_has_h`=1 and `cur_virt`=0 sets the new privilege to {0,`st_spp`} and `new_virt` to `hs_spv`. It clears `new_spv` and `new_spp`, copies `st_spie` into `new_sie` and sets `new_spie` to 1. The machine fields pass through unchanged.
- R7: Any other supervisor return behaves as follows. The new privilege is {0,`st_spp`}. `new_sie` takes `st_spie`. `new_spie` becomes 1 and `new_spp` becomes 0. `new_virt` keeps `cur_virt` and `new_spv` keeps `hs_spv`. The machine fields pass through unchanged.
- R8: Machine return sets the new privilege to `st_mpp` and copies `st_mpie` into `new_mie`. It sets `new_mpie` to 1, sets `new_mpp` to 0 and clears `new_mpv`. `new_virt` takes `st_mpv` when `cfg_has_h`=1 and keeps `cur_virt` otherwise. The supervisor fields pass through unchanged.
- R9: Third check, machine return only. When `cfg_rule_cnt`=0 and `st_mpp` is not 3, the unit faults with cause 2.
- R10: Each request gives exactly one result in the following cycle, and only the first failing check is reported. On success, `done` pulses and `ret_pc` takes the selected PC. A fault pulses `fault` with its cause, and all `new_*` outputs and `ret_pc` hold their values. With no request, neither `done` nor `fault` pulses and `fault_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle return request |
| req_is_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| cur_virt | input | 1 | Current virtualization flag |
| st_sie | input | 1 | Status: supervisor interrupt enable |
| st_spie | input | 1 | Status: supervisor prior interrupt enable |
| st_spp | input | 1 | Status: supervisor prior privilege |
| st_mie | input | 1 | Status: machine interrupt enable |
| st_mpie | input | 1 | Status: machine prior interrupt enable |
| st_mpp | input | 2 | Status: machine prior privilege |
| st_mpv | input | 1 | Status: machine prior virtualization |
| st_tsr | input | 1 | Status: trap supervisor returns |
| hs_spv | input | 1 | Hypervisor status: supervisor prior virtualization |
| hs_vtsr | input | 1 | Hypervisor status: trap supervisor returns from guests |
| sepc | input | XLEN | Supervisor saved exception PC |
| mepc | input | XLEN | Machine saved exception PC |
| cfg_has_c | input | 1 | Compressed instructions present |
| cfg_has_h | input | 1 | Hypervisor extension present |
| cfg_rule_cnt | input | RULE_W | Number of memory-protection rules |
| done | output | 1 | Successful return pulse |
| fault | output | 1 | Exception pulse |
| fault_cause | output | 5 | Cause code (0, 2 or 22) while `fault` is high |
| new_priv | output | 2 | Next privilege |
| new_virt | output | 1 | Next virtualization flag |
| new_sie | output | 1 | Updated supervisor interrupt enable |
| new_spie | output | 1 | Updated supervisor prior interrupt enable |
| new_spp | output | 1 | Updated supervisor prior privilege |
| new_mie | output | 1 | Updated machine interrupt enable |
| new_mpie | output | 1 | Updated machine prior interrupt enable |
| new_mpp | output | 2 | Updated machine prior privilege |
| new_mpv | output | 1 | Updated machine prior virtualization |
| new_spv | output | 1 | Updated supervisor prior virtualization |
| ret_pc | output | XLEN | Return PC |

## Verification
The bench targets requests where several checks fail at once. An example is a supervisor return at user level with a misaligned PC and the trap bit set. A unit with the priority order wrong would report cause 0 or cause 22 where cause 2 is due.

Other targets are faults that follow successful returns. A unit that wrote state on a fault would change the held `new_*` values or `ret_pc`. Machine returns with no protection rules are sent both to machine level and to lower levels. Supervisor returns are sent with the hypervisor extension both present and absent, and with virtualization both on and off. A unit that picked the wrong branch would drop or keep the stored guest flag, or leave the virtualization flag wrong.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam logic [1:0] PRV_USER  = 2'd0;
  localparam logic [1:0] PRV_SUPER = 2'd1;
  localparam logic [1:0] PRV_MACH  = 2'd3;

  typedef enum logic [4:0] {
    CAUSE_MISALIGN = 5'd0,
    CAUSE_ILLEGAL  = 5'd2,
    CAUSE_VIRT     = 5'd22
  } cause_e;

  typedef struct packed {
    logic       sie;
    logic       spie;
    logic       spp;
    logic       mie;
    logic       mpie;
    logic [1:0] mpp;
    logic       mpv;
    logic       spv;
  } stat_t;
endpackage

// File: rtl/trp_check.sv
module trp_check
  import trp_pkg::*;
#(
  parameter int RULE_W = 5
) (
  input  logic              is_mret,
  input  logic [1:0]        cur_priv,
  input  logic              cur_virt,
  input  logic              tsr,
  input  logic              vtsr,
  input  logic [1:0]        mpp,
  input  logic              has_c,
  input  logic              has_h,
  input  logic [RULE_W-1:0] rule_cnt,
  input  logic [1:0]        pc_lo,
  output logic              bad,
  output cause_e            cause
);
  logic priv_low, misalign, tsr_hit, vtsr_hit, prot_hit;

  always_comb begin
    priv_low = is_mret ? (cur_priv != PRV_MACH) : (cur_priv < PRV_SUPER);
    misalign = !has_c && (pc_lo != 2'b00);
    tsr_hit  = !is_mret && tsr && (cur_priv != PRV_MACH);
    vtsr_hit = !is_mret && has_h && cur_virt && vtsr;
    prot_hit = is_mret && (rule_cnt == '0) && (mpp != PRV_MACH);
  end

  // first failing check wins
  always_comb begin
    bad   = 1'b1;
    cause = CAUSE_ILLEGAL;
    if (priv_low)      cause = CAUSE_ILLEGAL;
    else if (misalign) cause = CAUSE_MISALIGN;
    else if (tsr_hit)  cause = CAUSE_ILLEGAL;
    else if (vtsr_hit) cause = CAUSE_VIRT;
    else if (prot_hit) cause = CAUSE_ILLEGAL;
    else               bad   = 1'b0;
  end
endmodule

// File: rtl/trp_update.sv
module trp_update
  import trp_pkg::*;
(
  input  logic       is_mret,
  input  logic       cur_virt,
  input  logic       has_h,
  input  stat_t      st_in,
  output stat_t      st_out,
  output logic [1:0] priv_out,
  output logic       virt_out
);
  always_comb begin
    st_out   = st_in;
    priv_out = PRV_USER;
    virt_out = cur_virt;
    if (is_mret) begin
      priv_out    = st_in.mpp;
      st_out.mie  = st_in.mpie;
      st_out.mpie = 1'b1;
      st_out.mpp  = PRV_USER;
      st_out.mpv  = 1'b0;
      if (has_h) virt_out = st_in.mpv;
    end else begin
      priv_out    = {1'b0, st_in.spp};
      st_out.sie  = st_in.spie;
      st_out.spie = 1'b1;
      st_out.spp  = 1'b0;
      if (has_h && !cur_virt) begin
        virt_out   = st_in.spv;
        st_out.spv = 1'b0;
      end
    end
  end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trp_pkg::*;
#(
  parameter  int XLEN      = 32,
  parameter  int MAX_RULES = 16,
  localparam int RULE_W    = $clog2(MAX_RULES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_is_mret,
  input  logic [1:0]        cur_priv,
  input  logic              cur_virt,
  input  logic              st_sie,
  input  logic              st_spie,
  input  logic              st_spp,
  input  logic              st_mie,
  input  logic              st_mpie,
  input  logic [1:0]        st_mpp,
  input  logic              st_mpv,
  input  logic              st_tsr,
  input  logic              hs_spv,
  input  logic              hs_vtsr,
  input  logic [XLEN-1:0]   sepc,
  input  logic [XLEN-1:0]   mepc,
  input  logic              cfg_has_c,
  input  logic              cfg_has_h,
  input  logic [RULE_W-1:0] cfg_rule_cnt,
  output logic              done,
  output logic              fault,
  output logic [4:0]        fault_cause,
  output logic [1:0]        new_priv,
  output logic              new_virt,
  output logic              new_sie,
  output logic              new_spie,
  output logic              new_spp,
  output logic              new_mie,
  output logic              new_mpie,
  output logic [1:0]        new_mpp,
  output logic              new_mpv,
  output logic              new_spv,
  output logic [XLEN-1:0]   ret_pc
);
  logic [XLEN-1:0] sel_pc;
  logic            chk_bad;
  cause_e          chk_cause;
  stat_t           st_cur, st_nxt, st_q;
  logic [1:0]      priv_nxt;
  logic            virt_nxt;

  assign sel_pc = req_is_mret ? mepc : sepc;
  assign st_cur = '{sie: st_sie, spie: st_spie, spp: st_spp, mie: st_mie,
                    mpie: st_mpie, mpp: st_mpp, mpv: st_mpv, spv: hs_spv};

  trp_check #(.RULE_W(RULE_W)) u_check (
    .is_mret  (req_is_mret),
    .cur_priv (cur_priv),
    .cur_virt (cur_virt),
    .tsr      (st_tsr),
    .vtsr     (hs_vtsr),
    .mpp      (st_mpp),
    .has_c    (cfg_has_c),
    .has_h    (cfg_has_h),
    .rule_cnt (cfg_rule_cnt),
    .pc_lo    (sel_pc[1:0]),
    .bad      (chk_bad),
    .cause    (chk_cause)
  );

  trp_update u_update (
    .is_mret  (req_is_mret),
    .cur_virt (cur_virt),
    .has_h    (cfg_has_h),
    .st_in    (st_cur),
    .st_out   (st_nxt),
    .priv_out (priv_nxt),
    .virt_out (virt_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_cause <= '0;
      new_priv    <= PRV_USER;
      new_virt    <= 1'b0;
      st_q        <= '0;
      ret_pc      <= '0;
    end else begin
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_cause <= '0;
      if (req_valid) begin
        if (chk_bad) begin
          fault       <= 1'b1;
          fault_cause <= chk_cause;
        end else begin
          done     <= 1'b1;
          new_priv <= priv_nxt;
          new_virt <= virt_nxt;
          st_q     <= st_nxt;
          ret_pc   <= sel_pc;
        end
      end
    end
  end

  assign new_sie  = st_q.sie;
  assign new_spie = st_q.spie;
  assign new_spp  = st_q.spp;
  assign new_mie  = st_q.mie;
  assign new_mpie = st_q.mpie;
  assign new_mpp  = st_q.mpp;
  assign new_mpv  = st_q.mpv;
  assign new_spv  = st_q.spv;

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    !(done && fault)); // R10
  AST_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (done || fault) |-> $past(req_valid)); // R10
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    fault |-> ($stable(new_priv) && $stable(ret_pc) && $stable(st_q))); // R10
  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (rst)
    fault |-> (fault_cause == 5'd0 || fault_cause == 5'd2 || fault_cause == 5'd22)); // R10
  AST_PRIV_GATE: assert property (@(posedge clk) disable iff (rst)
    (fault && $past(req_is_mret) && $past(cur_priv) != PRV_MACH) |-> fault_cause == 5'd2); // R2
  AST_ALIGNED_PC: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(cfg_has_c)) |-> ret_pc[1:0] == 2'b00); // R3
  AST_MRET_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (done && $past(req_is_mret)) |-> (new_mpp == PRV_USER && !new_mpv && new_mpie)); // R8
  AST_SRET_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(req_is_mret)) |-> (new_spie && !new_spp)); // R7
  AST_NO_RULES: assert property (@(posedge clk) disable iff (rst)
    (done && $past(req_is_mret) && $past(cfg_rule_cnt) == '0) |-> new_priv == PRV_MACH); // R9
endmodule

// File: tb/trap_return_unit_test.sv
module trap_return_unit_test;
  localparam int XLEN   = 32;
  localparam int RULE_W = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, req_valid, req_is_mret, cur_virt;
  logic [1:0] cur_priv, st_mpp;
  logic st_sie, st_spie, st_spp, st_mie, st_mpie, st_mpv, st_tsr, hs_spv, hs_vtsr;
  logic [XLEN-1:0] sepc, mepc;
  logic cfg_has_c, cfg_has_h;
  logic [RULE_W-1:0] cfg_rule_cnt;
  logic done, fault, new_virt, new_sie, new_spie, new_spp, new_mie, new_mpie, new_mpv, new_spv;
  logic [4:0] fault_cause;
  logic [1:0] new_priv, new_mpp;
  logic [XLEN-1:0] ret_pc;

  trap_return_unit #(.XLEN(XLEN), .MAX_RULES(16)) uut (.*);

  // reference model state
  logic m_done, m_fault, m_virt, m_sie, m_spie, m_spp, m_mie, m_mpie, m_mpv, m_spv;
  logic [4:0] m_cause;
  logic [1:0] m_priv, m_mpp;
  logic [XLEN-1:0] m_pc;
  string m_tag;
  int n_cmp = 0;
  int n_bad = 0;

  task automatic model_reset();
    {m_done, m_fault, m_virt, m_sie, m_spie, m_spp, m_mie, m_mpie, m_mpv, m_spv} = '0;
    m_cause = 0; m_priv = 0; m_mpp = 0; m_pc = 0; m_tag = "R1";
  endtask

  task automatic model_step();
    int code;
    logic [XLEN-1:0] pc;
    m_done = 0; m_fault = 0; m_cause = 0;
    if (!req_valid) begin m_tag = "R10"; return; end
    pc = req_is_mret ? mepc : sepc;
    code = -1;
    if (req_is_mret) begin
      if (cur_priv != 2'd3) begin code = 2; m_tag = "R2"; end
      else if (!cfg_has_c && pc[1:0] != 0) begin code = 0; m_tag = "R3"; end
      else if (cfg_rule_cnt == 0 && st_mpp != 2'd3) begin code = 2; m_tag = "R9"; end
    end else begin
      if (cur_priv == 2'd0) begin code = 2; m_tag = "R2"; end
      else if (!cfg_has_c && pc[1:0] != 0) begin code = 0; m_tag = "R3"; end
      else if (st_tsr && cur_priv != 2'd3) begin code = 2; m_tag = "R4"; end
      else if (cfg_has_h && cur_virt && hs_vtsr) begin code = 22; m_tag = "R5"; end
    end
    if (code >= 0) begin
      m_fault = 1; m_cause = code[4:0];
      return;
    end
    m_done = 1; m_pc = pc;
    // pass-through defaults
    m_sie = st_sie; m_spie = st_spie; m_spp = st_spp; m_spv = hs_spv;
    m_mie = st_mie; m_mpie = st_mpie; m_mpp = st_mpp; m_mpv = st_mpv;
    m_virt = cur_virt;
    if (req_is_mret) begin
      m_tag = "R8";
      m_priv = st_mpp; m_mie = st_mpie; m_mpie = 1; m_mpp = 0; m_mpv = 0;
      if (cfg_has_h) m_virt = st_mpv;
    end else if (cfg_has_h && !cur_virt) begin
      m_tag = "R6";
      m_priv = {1'b0, st_spp}; m_virt = hs_spv; m_spv = 0; m_spp = 0;
      m_sie = st_spie; m_spie = 1;
    end else begin
      m_tag = "R7";
      m_priv = {1'b0, st_spp}; m_sie = st_spie; m_spie = 1; m_spp = 0;
    end
  endtask

  task automatic compare();
    logic [XLEN+19:0] act, exp;
    act = {done, fault, fault_cause, new_priv, new_virt, new_sie, new_spie, new_spp,
           new_mie, new_mpie, new_mpp, new_mpv, new_spv, ret_pc};
    exp = {m_done, m_fault, m_cause, m_priv, m_virt, m_sie, m_spie, m_spp,
           m_mie, m_mpie, m_mpp, m_mpv, m_spv, m_pc};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", m_tag, act, exp);
    end
  endtask

  task automatic drive_random();
    int p;
    req_valid   = ($urandom % 10) < 7;
    req_is_mret = $urandom % 2;
    p = $urandom % 3;
    cur_priv    = (p == 2) ? 2'd3 : 2'(p);
    cur_virt    = $urandom % 2;
    {st_sie, st_spie, st_spp, st_mie, st_mpie, st_mpv, hs_spv} = 7'($urandom);
    st_mpp      = (($urandom % 3) == 2) ? 2'd3 : 2'($urandom % 2);
    st_tsr      = ($urandom % 4) == 0;
    hs_vtsr     = $urandom % 2;
    sepc        = ($urandom % 3 == 0) ? $urandom : ($urandom & ~32'd3);
    mepc        = ($urandom % 3 == 0) ? $urandom : ($urandom & ~32'd3);
    cfg_has_c   = $urandom % 2;
    cfg_has_h   = $urandom % 2;
    cfg_rule_cnt = (($urandom % 4) == 0) ? '0 : RULE_W'(1 + $urandom % 16);
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_is_mret = 0; cur_priv = 2'd3; cur_virt = 0;
    {st_sie, st_spie, st_spp, st_mie, st_mpie, st_mpv, hs_spv, st_tsr, hs_vtsr} = '0;
    st_mpp = 0; sepc = 0; mepc = 0; cfg_has_c = 0; cfg_has_h = 0; cfg_rule_cnt = 0;
  endtask

  // one clock: drive at negedge, compare at next negedge
  task automatic cycle();
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    compare(); // R1 reset state
    // R2 wins over misalignment, TSR: sret at user, misaligned, tsr set
    req_valid = 1; req_is_mret = 0; cur_priv = 0; sepc = 32'h103; st_tsr = 1; cycle();
    // R3 then R4: sret at supervisor, misaligned, tsr set
    cur_priv = 1; cycle();
    cfg_has_c = 1; cycle();                 // R4 now
    // R5: virtual trap of sret
    st_tsr = 0; cfg_has_h = 1; cur_virt = 1; hs_vtsr = 1; cycle();
    // R6 success with H and virt off
    cur_virt = 0; st_spp = 1; hs_spv = 1; st_spie = 1; sepc = 32'h2000; cycle();
    // R9: mret no rules, mpp user, then mpp machine succeeds (R8)
    req_is_mret = 1; cur_priv = 3; st_mpp = 0; st_mpv = 1; st_mpie = 1; mepc = 32'h400; cycle();
    st_mpp = 3; cycle();
    // R10 idle cycle, fault holds state
    req_valid = 0; cycle();
    req_valid = 1; cur_priv = 1; cycle();
    for (int i = 0; i < 6000; i++) begin
      drive_random();
      cycle();
    end
    idle_inputs();
    cycle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule